// File: doc/BRIEF.md
# Single-Channel Memory Copy DMA Engine

This block is one memory-to-memory copy channel with a controller-wide enable, programmed through a 32-bit register port. Software first sets the global enable. It then loads the byte count as length minus one, along with the source and destination start addresses and a burst shape for each side. It launches the copy with a single combined write to the channel control word.

The engine moves the data in chunks. Each chunk is read completely into an internal byte buffer and then written back out. Both phases use a valid/ready request port with a single response channel. When the copy ends, a 4-bit status code is posted and, if enabled, an interrupt is raised. Software acknowledges by writing zero to the status field, which also stops the channel. Clearing the channel enable during a copy aborts it.

The memory port obeys the usual back-pressure rules. While `mreq_valid` is high and `mreq_ready` is low, the request and its fields hold steady. A request is transferred on a cycle where both are high. Only one request is outstanding at a time: the next request is not issued until the response to the previous one has been accepted on `mrsp_valid`. `mrsp_ready` is held high, so a response is always taken in the cycle it appears.

Top module: `dmac_copy_chan`

## Requirements
- R1: After reset every register reads zero, except the two access configuration words (0x1C source, 0x20 destination), which read 0x0003_0F00. `irq` and `mreq_valid` are low.
- R2: The count register (0x10) holds bytes minus one. Exactly count+1 bytes are copied from the source address (0x14) to the destination address (0x18), so a count of 0 copies one byte. The byte just past the destination range is left untouched.
- R3: A copy starts only on a write to 0x28 with bit 28 (channel enable) set, bit 24 (start) set and bits 23:20 equal to 1. Global bit 28 at 0x00 must also be set and the channel must be idle. A start that misses any condition is ignored: no memory request is made, the status stays 0, and the start is not remembered. Bit 24 always reads 0.
- R4: In each access configuration word, bits 17:16 give the beat width as 2^value bytes and bits 11:8 give the beats per burst as value+1. Each chunk is the minimum of the bytes remaining, the source burst bytes and the destination burst bytes. Each chunk is read in full and then written in full. `mreq_last` marks the final beat of every chunk on each side. No beat is wider than its side's configured width.
- R5: A request held with `mreq_ready` low keeps its address, direction and size. No new request is offered while a response is due.
- R6: Normal completion sets the status field (0x30, bits 3:0) to 0x8. `irq` is then high if bit 0 of 0x28 (completion interrupt enable) is set, and low otherwise.
- R7: A response with `mrsp_err` set posts status 0x1 and stops the channel, so no further requests are made. `irq` is raised only if bit 1 of 0x28 (error interrupt enable) is set.
- R8: Writing 0 to bits 3:0 of 0x30 clears the status, drops `irq` by the next cycle, and clears the channel enable (bit 28 of 0x28). Writing a nonzero value there has no effect.
- R9: Clearing bit 28 of 0x28 during a copy stops it. From the next cycle no request is offered, and the status stays 0.
- R10: While global bit 28 at 0x00 is clear, `mreq_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Channel interrupt |
| mreq_valid | output | 1 | Memory request valid |
| mreq_ready | input | 1 | Memory request ready |
| mreq_write | output | 1 | 1 = write beat, 0 = read beat |
| mreq_addr | output | ADDR_W | Byte address of the beat |
| mreq_size_m1 | output | 3 | Bytes in the beat minus one |
| mreq_last | output | 1 | Final beat of the current chunk |
| mreq_wdata | output | 64 | Write bytes, lowest address in bits 7:0 |
| mrsp_valid | input | 1 | Response valid |
| mrsp_ready | output | 1 | Response ready (held high) |
| mrsp_rdata | input | 64 | Read bytes, lowest address in bits 7:0 |
| mrsp_err | input | 1 | Response carries an error |

## Verification
The hardest situations to reach are the ones that interrupt a copy part-way through a chunk. One is an error response in the middle of a chunk's read phase. The other is a channel-enable clear that lands while a request is waiting or a response is still in flight.

The bench memory model has an address window that returns errors, placed a few beats into the first chunk. The abort is a timed control write made many cycles into a long copy. In both cases the bench counts handshakes for a stretch afterwards to show that the port stays quiet.

Chunk boundaries are exercised separately. The table pairs different source and destination burst shapes so that the shorter side sets the chunk size, and the final chunk comes out shortened.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam logic [7:0] OFS_GLOBAL = 8'h00;
  localparam logic [7:0] OFS_COUNT  = 8'h10;
  localparam logic [7:0] OFS_SRC    = 8'h14;
  localparam logic [7:0] OFS_DST    = 8'h18;
  localparam logic [7:0] OFS_SCFG   = 8'h1C;
  localparam logic [7:0] OFS_DCFG   = 8'h20;
  localparam logic [7:0] OFS_CTRL   = 8'h28;
  localparam logic [7:0] OFS_STAT   = 8'h30;

  localparam int BIT_ENABLE = 28;
  localparam int BIT_GO     = 24;
  localparam int BIT_ERR_IE = 1;
  localparam int BIT_END_IE = 0;

  localparam logic [3:0] KIND_MEMCPY = 4'h1;
  localparam logic [3:0] ST_DONE     = 4'h8;
  localparam logic [3:0] ST_FAULT    = 4'h1;

  typedef enum logic [1:0] {PH_IDLE, PH_READ, PH_WRITE} phase_t;

  typedef struct packed {
    logic [1:0] size;
    logic [3:0] len;
  } burst_t;
endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic              fault,
  output logic              gen_en,
  output logic              ch_en,
  output logic              go,
  output logic [CNT_W-1:0]  cnt,
  output logic [ADDR_W-1:0] src,
  output logic [ADDR_W-1:0] dst,
  output burst_t            scfg,
  output burst_t            dcfg,
  output logic [3:0]        status,
  output logic              irq
);
  logic [3:0] kind_q;
  logic       err_ie_q, end_ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_en   <= 1'b0;
      ch_en    <= 1'b0;
      cnt      <= '0;
      src      <= '0;
      dst      <= '0;
      scfg     <= '{size: 2'd3, len: 4'hF};
      dcfg     <= '{size: 2'd3, len: 4'hF};
      kind_q   <= '0;
      err_ie_q <= 1'b0;
      end_ie_q <= 1'b0;
      status   <= '0;
    end else begin
      if (done) status <= ST_DONE;
      else if (fault) status <= ST_FAULT;
      if (reg_we) begin
        case (reg_addr)
          OFS_GLOBAL: gen_en <= reg_wdata[BIT_ENABLE];
          OFS_COUNT:  cnt    <= reg_wdata[CNT_W-1:0];
          OFS_SRC:    src    <= reg_wdata[ADDR_W-1:0];
          OFS_DST:    dst    <= reg_wdata[ADDR_W-1:0];
          OFS_SCFG:   scfg   <= '{size: reg_wdata[17:16], len: reg_wdata[11:8]};
          OFS_DCFG:   dcfg   <= '{size: reg_wdata[17:16], len: reg_wdata[11:8]};
          OFS_CTRL: begin
            ch_en    <= reg_wdata[BIT_ENABLE];
            kind_q   <= reg_wdata[23:20];
            err_ie_q <= reg_wdata[BIT_ERR_IE];
            end_ie_q <= reg_wdata[BIT_END_IE];
          end
          OFS_STAT: begin
            if (reg_wdata[3:0] == 4'h0) begin
              status <= '0;
              ch_en  <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign go = reg_we && (reg_addr == OFS_CTRL) && reg_wdata[BIT_ENABLE] &&
              reg_wdata[BIT_GO] && (reg_wdata[23:20] == KIND_MEMCPY) &&
              gen_en && !busy;

  assign irq = ((status == ST_DONE) && end_ie_q) || ((status == ST_FAULT) && err_ie_q);

  always_comb begin
    case (reg_addr)
      OFS_GLOBAL: reg_rdata = {3'b0, gen_en, 28'b0};
      OFS_COUNT:  reg_rdata = 32'(cnt);
      OFS_SRC:    reg_rdata = 32'(src);
      OFS_DST:    reg_rdata = 32'(dst);
      OFS_SCFG:   reg_rdata = {14'b0, scfg.size, 4'b0, scfg.len, 8'b0};
      OFS_DCFG:   reg_rdata = {14'b0, dcfg.size, 4'b0, dcfg.len, 8'b0};
      OFS_CTRL:   reg_rdata = {3'b0, ch_en, 4'b0, kind_q, 18'b0, err_ie_q, end_ie_q};
      OFS_STAT:   reg_rdata = {28'b0, status};
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dmac_bytebuf.sv
module dmac_bytebuf #(
  parameter int BEAT_BYTES  = 8,
  parameter int DEPTH_BYTES = 128,
  localparam int OFF_W  = $clog2(DEPTH_BYTES) + 1,
  localparam int IDX_W  = $clog2(DEPTH_BYTES),
  localparam int DATA_W = BEAT_BYTES * 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [OFF_W-1:0]  wr_cnt,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data
);
  logic [7:0] mem [DEPTH_BYTES];
  logic [DEPTH_BYTES-1:0] hit;
  logic [7:0] lane [DEPTH_BYTES];

  for (genvar i = 0; i < DEPTH_BYTES; i++) begin : g_cell
    logic [OFF_W-1:0] rel;
    assign rel     = OFF_W'(i) - wr_off;
    assign hit[i]  = (OFF_W'(i) >= wr_off) && (rel < wr_cnt);
    assign lane[i] = 8'(wr_data >> {rel, 3'b000});
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int i = 0; i < DEPTH_BYTES; i++) begin
        if (hit[i]) mem[i] <= lane[i];
      end
    end
  end

  for (genvar k = 0; k < BEAT_BYTES; k++) begin : g_rd
    assign rd_data[k*8 +: 8] = mem[IDX_W'(rd_off + OFF_W'(k))];
  end
endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
  import dmac_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 32,
  parameter int BEAT_BYTES = 8,
  parameter int MAX_BEATS  = 16,
  localparam int BUF_BYTES = BEAT_BYTES * MAX_BEATS,
  localparam int OFF_W     = $clog2(BUF_BYTES) + 1,
  localparam int SZ_W      = $clog2(BEAT_BYTES),
  localparam int DATA_W    = BEAT_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              ch_en,
  input  logic              gen_en,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  input  burst_t            scfg,
  input  burst_t            dcfg,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic              mreq_valid,
  input  logic              mreq_ready,
  output logic              mreq_write,
  output logic [ADDR_W-1:0] mreq_addr,
  output logic [SZ_W-1:0]   mreq_size_m1,
  output logic              mreq_last,
  output logic [DATA_W-1:0] mreq_wdata,
  input  logic              mrsp_valid,
  output logic              mrsp_ready,
  input  logic              mrsp_err,
  output logic              bw_en,
  output logic [OFF_W-1:0]  bw_off,
  output logic [OFF_W-1:0]  bw_cnt,
  output logic [OFF_W-1:0]  br_off,
  input  logic [DATA_W-1:0] br_data
);
  phase_t            ph;
  logic              waiting;
  logic [CNT_W:0]    rem;
  logic [ADDR_W-1:0] sa, da;
  logic [OFF_W-1:0]  chunk, off;
  logic [OFF_W-1:0]  s_bytes, d_bytes, cap, room, beat;
  logic              last;

  function automatic logic [OFF_W-1:0] pick(input logic [CNT_W:0] left,
                                            input logic [OFF_W-1:0] a,
                                            input logic [OFF_W-1:0] b);
    logic [OFF_W-1:0] m;
    m = (a < b) ? a : b;
    return (left < (CNT_W+1)'(m)) ? left[OFF_W-1:0] : m;
  endfunction

  assign s_bytes = OFF_W'(OFF_W'(scfg.len) + OFF_W'(1)) << scfg.size;
  assign d_bytes = OFF_W'(OFF_W'(dcfg.len) + OFF_W'(1)) << dcfg.size;
  assign cap     = OFF_W'(1) << ((ph == PH_WRITE) ? dcfg.size : scfg.size);
  assign room    = chunk - off;
  assign beat    = (room < cap) ? room : cap;
  assign last    = (beat == room);

  assign busy         = (ph != PH_IDLE);
  assign mreq_valid   = busy && !waiting && gen_en && ch_en;
  assign mreq_write   = (ph == PH_WRITE);
  assign mreq_addr    = mreq_write ? da : sa;
  assign mreq_size_m1 = SZ_W'(beat - OFF_W'(1));
  assign mreq_last    = last;
  assign mrsp_ready   = 1'b1;

  for (genvar k = 0; k < BEAT_BYTES; k++) begin : g_lane
    assign mreq_wdata[k*8 +: 8] = (mreq_write && (OFF_W'(k) < beat)) ? br_data[k*8 +: 8] : 8'h00;
  end

  assign bw_en  = (ph == PH_READ) && waiting && mrsp_valid && !mrsp_err;
  assign bw_off = off;
  assign bw_cnt = beat;
  assign br_off = off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      waiting <= 1'b0;
      rem     <= '0;
      sa      <= '0;
      da      <= '0;
      chunk   <= '0;
      off     <= '0;
      done    <= 1'b0;
      fault   <= 1'b0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      if (busy && !ch_en) begin
        ph      <= PH_IDLE;
        waiting <= 1'b0;
      end else begin
        case (ph)
          PH_IDLE: begin
            if (go) begin
              rem     <= (CNT_W+1)'(cnt) + (CNT_W+1)'(1);
              chunk   <= pick((CNT_W+1)'(cnt) + (CNT_W+1)'(1), s_bytes, d_bytes);
              sa      <= src;
              da      <= dst;
              off     <= '0;
              waiting <= 1'b0;
              ph      <= PH_READ;
            end
          end
          default: begin
            if (mreq_valid && mreq_ready) waiting <= 1'b1;
            if (waiting && mrsp_valid) begin
              waiting <= 1'b0;
              if (mrsp_err) begin
                fault <= 1'b1;
                ph    <= PH_IDLE;
              end else if (ph == PH_READ) begin
                sa <= sa + ADDR_W'(beat);
                if (last) begin
                  off <= '0;
                  ph  <= PH_WRITE;
                end else begin
                  off <= off + beat;
                end
              end else begin
                da <= da + ADDR_W'(beat);
                if (last) begin
                  off <= '0;
                  if (rem == (CNT_W+1)'(chunk)) begin
                    done <= 1'b1;
                    ph   <= PH_IDLE;
                  end else begin
                    rem   <= rem - (CNT_W+1)'(chunk);
                    chunk <= pick(rem - (CNT_W+1)'(chunk), s_bytes, d_bytes);
                    ph    <= PH_READ;
                  end
                end else begin
                  off <= off + beat;
                end
              end
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/dmac_copy_chan.sv
module dmac_copy_chan
  import dmac_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 32,
  parameter int BEAT_BYTES = 8,
  parameter int MAX_BEATS  = 16,
  localparam int BUF_BYTES = BEAT_BYTES * MAX_BEATS,
  localparam int OFF_W     = $clog2(BUF_BYTES) + 1,
  localparam int SZ_W      = $clog2(BEAT_BYTES),
  localparam int DATA_W    = BEAT_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              mreq_valid,
  input  logic              mreq_ready,
  output logic              mreq_write,
  output logic [ADDR_W-1:0] mreq_addr,
  output logic [SZ_W-1:0]   mreq_size_m1,
  output logic              mreq_last,
  output logic [DATA_W-1:0] mreq_wdata,
  input  logic              mrsp_valid,
  output logic              mrsp_ready,
  input  logic [DATA_W-1:0] mrsp_rdata,
  input  logic              mrsp_err
);
  logic              gen_en, ch_en, go, busy, done, fault;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] src, dst;
  burst_t            scfg, dcfg;
  logic [3:0]        stat_w;
  logic [1:0]        ssize_w;
  logic              bw_en;
  logic [OFF_W-1:0]  bw_off, bw_cnt, br_off;
  logic [DATA_W-1:0] br_data;

  assign ssize_w = scfg.size;

  dmac_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .done(done),
    .fault(fault), .gen_en(gen_en), .ch_en(ch_en), .go(go), .cnt(cnt),
    .src(src), .dst(dst), .scfg(scfg), .dcfg(dcfg), .status(stat_w), .irq(irq)
  );

  dmac_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BEAT_BYTES(BEAT_BYTES),
             .MAX_BEATS(MAX_BEATS)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .ch_en(ch_en), .gen_en(gen_en),
    .cnt(cnt), .src(src), .dst(dst), .scfg(scfg), .dcfg(dcfg),
    .busy(busy), .done(done), .fault(fault),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_write(mreq_write),
    .mreq_addr(mreq_addr), .mreq_size_m1(mreq_size_m1), .mreq_last(mreq_last),
    .mreq_wdata(mreq_wdata), .mrsp_valid(mrsp_valid), .mrsp_ready(mrsp_ready),
    .mrsp_err(mrsp_err), .bw_en(bw_en), .bw_off(bw_off), .bw_cnt(bw_cnt),
    .br_off(br_off), .br_data(br_data)
  );

  dmac_bytebuf #(.BEAT_BYTES(BEAT_BYTES), .DEPTH_BYTES(BUF_BYTES)) u_buf (
    .clk(clk), .wr_en(bw_en), .wr_off(bw_off), .wr_cnt(bw_cnt),
    .wr_data(mrsp_rdata), .rd_off(br_off), .rd_data(br_data)
  );
endmodule

// File: rtl/dmac_copy_chan_chk.sv
module dmac_copy_chan_chk #(
  parameter int ADDR_W = 32,
  parameter int SZ_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [7:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              irq,
  input logic              mreq_valid,
  input logic              mreq_ready,
  input logic              mreq_write,
  input logic [ADDR_W-1:0] mreq_addr,
  input logic [SZ_W-1:0]   mreq_size_m1,
  input logic              mrsp_valid,
  input logic [3:0]        status,
  input logic [1:0]        ssize
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && !mreq_ready && !reg_we |=> mreq_valid && $stable(mreq_addr) &&
    $stable(mreq_write) && $stable(mreq_size_m1)); // R5

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    mrsp_valid |-> !mreq_valid); // R5

  AST_RD_BEAT_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && !mreq_write |-> ({1'b0, mreq_size_m1} + 4'd1) <= (4'd1 << ssize)); // R4

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status != 4'h0); // R6

  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == 8'h30 && reg_wdata[3:0] == 4'h0 |=> !irq); // R8

  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == 8'h28 && !reg_wdata[28] |=> !mreq_valid); // R9

  AST_GLOBAL_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == 8'h00 && !reg_wdata[28] |=> !mreq_valid); // R10
endmodule

bind dmac_copy_chan dmac_copy_chan_chk #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq(irq), .mreq_valid(mreq_valid),
  .mreq_ready(mreq_ready), .mreq_write(mreq_write), .mreq_addr(mreq_addr),
  .mreq_size_m1(mreq_size_m1), .mrsp_valid(mrsp_valid), .status(stat_w),
  .ssize(ssize_w)
);

// File: tb/dmac_copy_chan_tb.sv
module dmac_copy_chan_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] GO_WORD = 32'h1110_0000;

  // [63:48] count-1, [47:32] src, [31:16] dst, [15:12] ssz, [11:8] sbl, [7:4] dsz, [3:0] dbl
  localparam logic [63:0] VEC [5] = '{
    64'h000F_0010_0200_3F3F,
    64'h012B_0003_0181_3F3F,
    64'h0027_0020_0301_0321,
    64'h0014_0050_03A0_1230,
    64'h0000_007F_03F0_3F3F
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        mreq_valid, mreq_ready, mreq_write, mreq_last;
  logic [31:0] mreq_addr;
  logic [2:0]  mreq_size_m1;
  logic [63:0] mreq_wdata;
  logic        mrsp_valid, mrsp_ready, mrsp_err;
  logic [63:0] mrsp_rdata;

  logic [7:0]  mem [0:1023];
  int          n_cmp = 0, n_bad = 0;
  int          n_req = 0, n_last = 0, n_wide = 0;
  int          cur_ssz = 3, cur_dsz = 3;
  logic        stall_on = 1'b0, err_on = 1'b0;
  logic [9:0]  err_lo = 10'h108;
  int          cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmac_copy_chan u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_write(mreq_write),
    .mreq_addr(mreq_addr), .mreq_size_m1(mreq_size_m1), .mreq_last(mreq_last),
    .mreq_wdata(mreq_wdata), .mrsp_valid(mrsp_valid), .mrsp_ready(mrsp_ready),
    .mrsp_rdata(mrsp_rdata), .mrsp_err(mrsp_err)
  );

  assign mreq_ready = stall_on ? cyc[1] : 1'b1;

  // memory model: one-cycle response after each accepted request
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      mrsp_valid <= 1'b0;
      mrsp_err   <= 1'b0;
      mrsp_rdata <= '0;
    end else begin
      mrsp_valid <= 1'b0;
      mrsp_err   <= 1'b0;
      if (mreq_valid && mreq_ready) begin
        logic [63:0] t;
        n_req = n_req + 1;
        if (mreq_last) n_last = n_last + 1;
        if ((int'(mreq_size_m1) + 1) > (1 << (mreq_write ? cur_dsz : cur_ssz))) n_wide = n_wide + 1;
        mrsp_valid <= 1'b1;
        if (mreq_write) begin
          for (int b = 0; b < 8; b++)
            if (b <= int'(mreq_size_m1)) mem[mreq_addr[9:0] + 10'(b)] <= mreq_wdata[b*8 +: 8];
        end else begin
          for (int b = 0; b < 8; b++) t[b*8 +: 8] = mem[mreq_addr[9:0] + 10'(b)];
          mrsp_rdata <= t;
          mrsp_err   <= err_on && (mreq_addr[9:0] >= err_lo) && (mreq_addr[9:0] < err_lo + 10'd8);
        end
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_status(output logic [31:0] st);
    st = '0;
    for (int i = 0; i < 6000 && st[3:0] == 4'h0; i++) rd(8'h30, st);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input int len_m1, input int s, input int d,
                       input int ssz, input int sbl, input int dsz, input int dbl);
    wr(8'h1C, 32'((ssz << 16) | (sbl << 8)));
    wr(8'h20, 32'((dsz << 16) | (dbl << 8)));
    wr(8'h10, 32'(len_m1));
    wr(8'h14, 32'(s));
    wr(8'h18, 32'(d));
    cur_ssz = ssz; cur_dsz = dsz;
  endtask

  logic [31:0] r;
  int          base_req, base_last;

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
    idle(3);
    rst_n = 1'b1;
    // R1: reset values
    rd(8'h00, r); check("R1 global", 64'(r), 64'h0);
    rd(8'h10, r); check("R1 count", 64'(r), 64'h0);
    rd(8'h1C, r); check("R1 src cfg", 64'(r), 64'h0003_0F00);
    rd(8'h20, r); check("R1 dst cfg", 64'(r), 64'h0003_0F00);
    rd(8'h28, r); check("R1 ctrl", 64'(r), 64'h0);
    rd(8'h30, r); check("R1 status", 64'(r), 64'h0);
    check("R1 irq", 64'(irq), 64'h0);
    check("R1 req", 64'(mreq_valid), 64'h0);
    wr(8'h00, 32'h1000_0000);

    // table of copies: R2, R4, R5, R6, R8
    for (int v = 0; v < 5; v++) begin
      int len, s, d, ssz, sbl, dsz, dbl, sb, db, ch, chunks, bad;
      logic [7:0] guard;
      len = int'(VEC[v][63:48]) + 1;
      s = int'(VEC[v][47:32]); d = int'(VEC[v][31:16]);
      ssz = int'(VEC[v][15:12]); sbl = int'(VEC[v][11:8]);
      dsz = int'(VEC[v][7:4]); dbl = int'(VEC[v][3:0]);
      sb = (sbl + 1) << ssz; db = (dbl + 1) << dsz;
      ch = (sb < db) ? sb : db;
      chunks = (len + ch - 1) / ch;
      stall_on = v[0];
      setup(len - 1, s, d, ssz, sbl, dsz, dbl);
      guard = mem[10'(d + len)];
      base_last = n_last; n_wide = 0;
      wr(8'h28, GO_WORD | 32'h1000_0003);
      wait_status(r);
      check("R6 done status", 64'(r[3:0]), 64'h8);
      check("R6 irq with end enable", 64'(irq), 64'h1);
      bad = 0;
      for (int i = 0; i < len; i++) if (mem[10'(d + i)] !== mem[10'(s + i)]) bad++;
      check("R2 copied bytes mismatching", 64'(bad), 64'h0);
      check("R2 guard byte", 64'(mem[10'(d + len)]), 64'(guard));
      check("R4 chunk last markers", 64'(n_last - base_last), 64'(2 * chunks));
      check("R4 beat width", 64'(n_wide), 64'h0);
      wr(8'h30, 32'h0);
      check("R8 irq after ack", 64'(irq), 64'h0);
      rd(8'h28, r); check("R8 enable cleared", 64'(r[28]), 64'h0);
    end
    stall_on = 1'b0;

    // R3: wrong transfer kind ignored; start bit reads zero
    setup(7, 16, 600, 3, 15, 3, 15);
    base_req = n_req;
    wr(8'h28, 32'h1120_0003);
    idle(20);
    check("R3 wrong kind no request", 64'(n_req - base_req), 64'h0);
    rd(8'h30, r); check("R3 wrong kind status", 64'(r), 64'h0);
    rd(8'h28, r); check("R3 start reads zero", 64'(r[24]), 64'h0);
    wr(8'h28, 32'h0);

    // R3 / R10: global clear blocks start, start not remembered
    wr(8'h00, 32'h0);
    base_req = n_req;
    wr(8'h28, GO_WORD | 32'h1000_0003);
    idle(20);
    check("R10 no request while global off", 64'(n_req - base_req), 64'h0);
    wr(8'h00, 32'h1000_0000);
    idle(20);
    check("R3 start not remembered", 64'(n_req - base_req), 64'h0);
    rd(8'h30, r); check("R3 status idle", 64'(r), 64'h0);
    wr(8'h28, 32'h0);

    // R9: abort mid copy
    setup(511, 0, 512, 3, 15, 3, 15);
    wr(8'h28, GO_WORD | 32'h1000_0003);
    idle(40);
    wr(8'h28, 32'h0000_0003);
    base_req = n_req;
    idle(50);
    check("R9 no request after abort", 64'(n_req - base_req), 64'h0);
    rd(8'h30, r); check("R9 status after abort", 64'(r), 64'h0);
    check("R9 irq after abort", 64'(irq), 64'h0);

    // R2: single byte after abort
    begin
      logic [7:0] g;
      setup(0, 60, 992, 3, 15, 3, 15);
      g = mem[10'd993];
      wr(8'h28, GO_WORD | 32'h1000_0003);
      wait_status(r);
      check("R2 one byte status", 64'(r[3:0]), 64'h8);
      check("R2 one byte copied", 64'(mem[10'd992]), 64'(mem[10'd60]));
      check("R2 one byte guard", 64'(mem[10'd993]), 64'(g));
      wr(8'h30, 32'h0);
    end

    // R7: error response, error interrupt enabled
    err_on = 1'b1;
    setup(31, 256, 640, 3, 15, 3, 15);
    wr(8'h28, GO_WORD | 32'h1000_0003);
    wait_status(r);
    check("R7 fault status", 64'(r[3:0]), 64'h1);
    check("R7 irq with error enable", 64'(irq), 64'h1);
    base_req = n_req;
    idle(20);
    check("R7 no request after fault", 64'(n_req - base_req), 64'h0);
    wr(8'h30, 32'h5);
    rd(8'h30, r); check("R8 nonzero write ignored", 64'(r[3:0]), 64'h1);
    check("R8 irq kept on nonzero write", 64'(irq), 64'h1);
    wr(8'h30, 32'h0);
    check("R8 irq dropped", 64'(irq), 64'h0);
    rd(8'h28, r); check("R8 enable cleared on ack", 64'(r[28]), 64'h0);

    // R7: error with error interrupt disabled
    wr(8'h28, GO_WORD | 32'h1000_0001);
    wait_status(r);
    check("R7 fault status quiet", 64'(r[3:0]), 64'h1);
    check("R7 irq masked", 64'(irq), 64'h0);
    wr(8'h30, 32'h0);
    err_on = 1'b0;

    // R6: completion with completion interrupt disabled
    setup(9, 300, 700, 3, 15, 3, 15);
    wr(8'h28, GO_WORD | 32'h1000_0002);
    wait_status(r);
    check("R6 done status masked", 64'(r[3:0]), 64'h8);
    check("R6 irq masked", 64'(irq), 64'h0);
    wr(8'h30, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule